// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block holds the tap position of a 64-step digitally controlled resistor divider. A host, a rotary encoder or a pair of buttons drives three wires: an active-low chip select, a direction level and a step strobe. The block runs on a fast system clock. It brings all three wires into that clock domain through flop chains and treats each falling edge of the strobe as one step request.

A qualified request moves the 6-bit position by exactly one step, up or down. The position stops at either end rather than wrapping around. An active-high synchronous reset models power-on and places the wiper at mid-scale, code 32. The block presents the position as a binary code and also as a one-hot select vector that drives the switch array directly.

Top module: `wiper_step_ctrl`

## Requirements
- R1: The position is a 6-bit unsigned code on `pos_o`, covering 0 through 63.
- R2: While `rst` is high at a rising `clk` edge, the position is loaded with 32. It reads 32 after reset until a step occurs.
- R3: Each high-to-low transition of `step_clk` produces at most one step. A low-to-high transition, or a level held for any time, produces none.
- R4: While `cs_n` is 1, falling edges of `step_clk` are ignored and the position holds.
- R5: With `cs_n` at 0, a falling edge moves the position up by one when `dir_up` is 1 and down by one when `dir_up` is 0. Repeated edges with the same `dir_up` keep moving the same way.
- R6: At code 63, further up steps leave the position at 63.
- R7: At code 0, further down steps leave the position at 0.
- R8: `tap_sel_o` has exactly one bit set, at bit index equal to the position. This also holds while reset is applied.
- R9: Suppose `step_clk` falls between two rising `clk` edges, and `cs_n` and `dir_up` are already settled. The position then changes at the third rising `clk` edge after the fall, and not before it.
- R10: If reset and a qualified step fall on the same `clk` edge, reset wins and the position becomes 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on model) |
| cs_n | input | 1 | Asynchronous chip select, active low |
| dir_up | input | 1 | Asynchronous direction, 1 = up, 0 = down |
| step_clk | input | 1 | Asynchronous step strobe, acts on its falling edge |
| pos_o | output | 6 | Binary wiper position |
| tap_sel_o | output | 64 | One-hot tap select, bit n set for position n |

## Verification
Reset and a step request can land on the same system clock edge. The bench arranges this by dropping the step strobe and raising reset for the single cycle in which the synchronised edge is recognised. It then expects mid-scale and not the moved value. The second collision is a step request arriving while the position already sits at an end. The bench drives more than enough pulses to run past 63 and past 0, and expects the position to remain pinned there with the one-hot select unchanged.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  localparam int POS_W   = 6;
  localparam int TAPS    = 1 << POS_W;
  localparam logic [POS_W-1:0] POS_MIN = '0;
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] POS_MID = POS_W'(TAPS / 2);

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [TAPS-1:0]  tap_t;

  // one saturating move of the wiper
  function automatic pos_t sat_step(pos_t p, logic up);
    if (up) return (p == POS_MAX) ? p : p + 1'b1;
    else    return (p == POS_MIN) ? p : p - 1'b1;
  endfunction

  function automatic tap_t tap_of(pos_t p);
    tap_t t;
    t = '0;
    t[p] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/wstep_sync.sv
module wstep_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wstep_fall.sv
module wstep_fall (
  input  logic clk,
  input  logic rst,
  input  logic s,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) prev <= s;

  assign fall = prev & ~s;

  // a single falling level change yields a one-cycle request
  assert_single_request_R3: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/wstep_pos.sv
module wstep_pos
  import wstep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_ok,
  input  logic up,
  output pos_t pos
);
  always_ff @(posedge clk) begin
    if (rst)          pos <= POS_MID;
    else if (step_ok) pos <= sat_step(pos, up);
  end

  assert_mid_after_reset_R2: assert property (@(posedge clk)
    $past(rst) |-> pos == POS_MID);
  assert_hold_no_request_R4: assert property (@(posedge clk) disable iff (rst)
    !step_ok |=> $stable(pos));
  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    (step_ok && up && pos != POS_MAX) |=> pos == $past(pos) + 1'b1);
  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (step_ok && !up && pos != POS_MIN) |=> pos == $past(pos) - 1'b1);
  assert_clamp_top_R6: assert property (@(posedge clk) disable iff (rst)
    (step_ok && up && pos == POS_MAX) |=> pos == POS_MAX);
  assert_clamp_bottom_R7: assert property (@(posedge clk) disable iff (rst)
    (step_ok && !up && pos == POS_MIN) |=> pos == POS_MIN);
endmodule

// File: rtl/wstep_tapdec.sv
module wstep_tapdec
  import wstep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  pos_t pos,
  output tap_t tap
);
  assign tap = tap_of(pos);

  assert_tap_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(tap) == 1);
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wstep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             dir_up,
  input  logic             step_clk,
  output logic [POS_W-1:0] pos_o,
  output logic [TAPS-1:0]  tap_sel_o
);
  localparam int NIN = 3;

  logic [NIN-1:0] raw_in, sync_in;
  logic cs_n_s, dir_s, step_s;
  logic step_fall;   // falling edge seen on the synchronised strobe
  logic step_ok;     // edge qualified by chip select
  pos_t pos;

  assign raw_in = {cs_n, dir_up, step_clk};

  wstep_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign {cs_n_s, dir_s, step_s} = sync_in;

  wstep_fall u_fall (
    .clk  (clk),
    .rst  (rst),
    .s    (step_s),
    .fall (step_fall)
  );

  assign step_ok = step_fall & ~cs_n_s;

  wstep_pos u_pos (
    .clk     (clk),
    .rst     (rst),
    .step_ok (step_ok),
    .up      (dir_s),
    .pos     (pos)
  );

  wstep_tapdec u_dec (
    .clk (clk),
    .rst (rst),
    .pos (pos),
    .tap (tap_sel_o)
  );

  assign pos_o = pos;

  assert_deselect_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |-> !step_ok);
endmodule

// File: tb/wiper_step_ctrl_tb.sv
module wiper_step_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic dir_up = 1'b0;
  logic step_clk = 1'b1;
  logic [5:0]  pos_o;
  logic [63:0] tap_sel_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wiper_step_ctrl u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .dir_up(dir_up),
    .step_clk(step_clk), .pos_o(pos_o), .tap_sel_o(tap_sel_o)
  );

  // vector: {cs_n, dir_up, expected position after one pulse}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 1'b1, 6'd33}, {1'b0, 1'b1, 6'd34}, {1'b1, 1'b1, 6'd34},
    {1'b0, 1'b0, 6'd33}, {1'b1, 1'b0, 6'd33}, {1'b0, 1'b0, 6'd32},
    {1'b0, 1'b0, 6'd31}, {1'b0, 1'b1, 6'd32}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_tap(input string req, input int p);
    checks++;
    if (tap_sel_o != (64'd1 << p)) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, tap_sel_o, 64'd1 << p);
    end
  endtask

  task automatic pulse(input logic cs, input logic d);
    @(negedge clk); cs_n = cs; dir_up = d;
    repeat (3) @(negedge clk);
    step_clk = 1'b0;
    repeat (5) @(negedge clk);
    step_clk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R8 tap during reset", tap_sel_o, 64'd1 << 32);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 reset value", pos_o, 32);
    chk_tap("R8 tap at mid", 32);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][7], VEC[i][6]);
      chk("R4 R5 R1 vector walk", pos_o, VEC[i][5:0]);
    end

    // R3: rising edge alone and held levels give no step
    @(negedge clk); cs_n = 1'b0; dir_up = 1'b1; step_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 first fall steps", pos_o, 33);
    step_clk = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 rise gives no step", pos_o, 33);

    // R9 latency: fall set just before a rising edge
    step_clk = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no change after two edges", pos_o, 33);
    @(negedge clk);
    chk("R9 change at third edge", pos_o, 34);
    step_clk = 1'b1;
    repeat (5) @(negedge clk);

    // R6: run past the top
    for (int i = 0; i < 35; i++) pulse(1'b0, 1'b1);
    chk("R6 clamp at top", pos_o, 63);
    chk_tap("R8 tap at top", 63);
    pulse(1'b0, 1'b1);
    chk("R6 stays at top", pos_o, 63);

    // R7: run past the bottom
    for (int i = 0; i < 70; i++) pulse(1'b0, 1'b0);
    chk("R7 clamp at bottom", pos_o, 0);
    chk_tap("R8 tap at bottom", 0);
    pulse(1'b1, 1'b1);
    chk("R4 deselected at bottom", pos_o, 0);
    pulse(1'b0, 1'b1);
    chk("R5 leave bottom", pos_o, 1);

    // R2 reset from an arbitrary position
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R2 reset returns to mid", pos_o, 32);

    // R10: reset in the same cycle as a qualified step
    @(negedge clk); cs_n = 1'b0; dir_up = 1'b1;
    repeat (3) @(negedge clk);
    step_clk = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 reset wins over step", pos_o, 32);
    repeat (5) @(negedge clk);
    chk("R10 no late step", pos_o, 32);
    step_clk = 1'b1;
    repeat (5) @(negedge clk);
    chk_tap("R8 tap after collision", 32);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule